// File: doc/BRIEF.md
# Paged I2C Register Target

This block is an I2C target that sits on an oversampled system clock. SCL and SDA are each brought in through a two-flop synchronizer. START and STOP conditions and SCL edges are found on the system clock. The block drives SDA low only through an open-drain enable. The 7-bit bus address carries a fixed upper part, and its two low bits are set by one strap pin. That pin has four possible connections: ground, supply, SCL or SDA. The block works out which one it is by watching the pin against the two bus lines.

After an address with the write bit comes a register-address byte that loads an internal pointer. Each further data byte is written at the pointer, and the pointer then steps by one. One register address acts as a command register. A byte written there does not reach the register file. It becomes the page selector, and every later pointer value refers to that page. Reads use a repeated START with the read bit set. Display (frame) pages are readable only while the shutdown input is high. The function page can be read at any time. The register storage lives outside the block and is reached through a plain address/data/write-enable port that also carries the current page.

The bus clock runs up to 400 kHz. The system clock must be at least eight times faster than the bus clock.

Top module: `i2c_page_slave`

## Requirements
- R1: After reset the block does not drive SDA (`sdaOe` = 0), `regPage` = 0x00, `regAddr` = 0x00 and `regWe` = 0.
- R2: A START is SDA falling while SCL is high. After a START, the block compares the first byte's upper seven bits, shifted MSB first, against the binary value 11101 followed by the two strap bits. On a match it holds SDA low for the ninth SCL clock. On a mismatch it leaves SDA released, and it ignores the rest of the transfer (no acknowledge, no `regWe`) until the next START.
- R3: The strap bits decode as follows: pin tied to ground gives 00, tied to supply gives 11, tied to SCL gives 01, tied to SDA gives 10. The strap bits are the two least significant bits of the 7-bit address.
- R4: After a matched address with the read/write bit (bit 0) at 0, the next byte is acknowledged and loaded into the pointer, which `regAddr` shows.
- R5: In a write, each following byte is acknowledged and presented on `regWData` with a one-cycle `regWe` at `regAddr`. The pointer then steps by one and wraps from 0xFF to 0x00.
- R6: A data byte written while the pointer is 0xFD raises no `regWe`. It becomes the page selector shown on `regPage`, and the bytes that follow in the same burst use the new page. Reading pointer 0xFD returns the page selector.
- R7: A repeated START followed by the address with bit 0 at 1 makes the block shift out the byte at the pointer, MSB first. The pointer steps by one after each byte the controller acknowledges. A NACK ends the read, and SDA stays released until the next START.
- R8: Page 0x0B (the function page) is readable at any time. Any other page returns its stored byte only while `shutdown` is 1. Otherwise it returns 0x00 and the stored contents stay unchanged.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle. Bytes clocked after a STOP and without a new START get no acknowledge. A repeated START in the middle of a write burst starts a fresh address phase.
- R10: The block changes `sdaOe` only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| strapPin | input | 1 | Four-way address strap (ground, supply, SCL or SDA) |
| shutdown | input | 1 | High when the device is in shutdown; allows frame-page reads |
| sdaOe | output | 1 | Open-drain enable; 1 pulls SDA low |
| regWe | output | 1 | One-cycle write strobe to the register file |
| regPage | output | 8 | Current page selector |
| regAddr | output | 8 | Register pointer within the page |
| regWData | output | 8 | Byte being written |
| regRData | input | 8 | Register-file data at `regPage`/`regAddr` |

## Verification
The checker covers four properties on every cycle. A write strobe lasts one cycle and advances the pointer by one. No write strobe is ever raised at the command address. The page selector changes only on the cycle after the pointer sat at the command address. `sdaOe` moves only while SCL is low. Address matching under each strap connection, the acknowledge pattern, the landing spots of a burst that crosses the command register, the contents returned by reads under the shutdown gate, and the silence after a mismatch or a STOP can only be shown through bus scenarios. The bench drives those scenarios as a bus controller and compares them against its own memory model.

// File: rtl/i2cpg_pkg.sv
package i2cpg_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WDATA,
    ST_RDATA
  } busState_t;

  // strobes from the bus control to the datapath
  typedef struct packed {
    logic shiftIn;
    logic setPtr;
    logic wrByte;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
  } strobe_t;
endpackage

// File: rtl/i2cpg_ctrl.sv
module i2cpg_ctrl
  import i2cpg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    addrMatch,
  input  logic    isRead,
  input  logic    txMsb,
  output logic    sclS,
  output logic    sdaS,
  output strobe_t strb,
  output logic    sdaOe
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  logic [1:0] sclPipe, sdaPipe;
  logic sclQ, sdaQ;
  logic sclRise, sclFall, startDet, stopDet;

  busState_t state, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic ackOe, ackNext, driveTx, drvNext, rdMode, rdNext, mNack, nackNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclQ    <= sclPipe[1];
      sdaQ    <= sdaPipe[1];
    end
  end

  assign sclS     = sclPipe[1];
  assign sdaS     = sdaPipe[1];
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;

  always_comb begin
    stNext   = state;
    cntNext  = bitCnt;
    ackNext  = ackOe;
    drvNext  = driveTx;
    rdNext   = rdMode;
    nackNext = mNack;
    strb     = '0;
    if (startDet) begin
      stNext  = ST_ADDR;
      cntNext = '0;
      ackNext = 1'b0;
      drvNext = 1'b0;
    end else if (stopDet) begin
      stNext  = ST_IDLE;
      cntNext = '0;
      ackNext = 1'b0;
      drvNext = 1'b0;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt < LAST_BIT) begin
          cntNext = bitCnt + 1'b1;
          if (state != ST_RDATA) strb.shiftIn = 1'b1;
        end else if (bitCnt == ACK_BIT && state == ST_RDATA) begin
          nackNext    = sdaS;
          strb.incPtr = ~sdaS;
        end
      end else if (sclFall) begin
        if (bitCnt == LAST_BIT) begin
          cntNext = ACK_BIT;
          case (state)
            ST_ADDR: begin
              if (addrMatch) begin
                ackNext = 1'b1;
                rdNext  = isRead;
              end else begin
                stNext  = ST_IDLE;
                cntNext = '0;
              end
            end
            ST_REG: begin
              ackNext     = 1'b1;
              strb.setPtr = 1'b1;
            end
            ST_WDATA: begin
              ackNext     = 1'b1;
              strb.wrByte = 1'b1;
            end
            default: drvNext = 1'b0;  // controller owns SDA for its ack
          endcase
        end else if (bitCnt == ACK_BIT) begin
          ackNext = 1'b0;
          cntNext = '0;
          case (state)
            ST_ADDR: begin
              if (rdMode) begin
                stNext      = ST_RDATA;
                strb.loadTx = 1'b1;
                drvNext     = 1'b1;
              end else begin
                stNext = ST_REG;
              end
            end
            ST_REG: stNext = ST_WDATA;
            ST_RDATA: begin
              if (mNack) begin
                stNext = ST_IDLE;
              end else begin
                strb.loadTx = 1'b1;
                drvNext     = 1'b1;
              end
            end
            default: ;
          endcase
        end else if (state == ST_RDATA && bitCnt != '0) begin
          strb.shiftTx = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ackOe   <= 1'b0;
      driveTx <= 1'b0;
      rdMode  <= 1'b0;
      mNack   <= 1'b0;
    end else begin
      state   <= stNext;
      bitCnt  <= cntNext;
      ackOe   <= ackNext;
      driveTx <= drvNext;
      rdMode  <= rdNext;
      mNack   <= nackNext;
    end
  end

  assign sdaOe = ackOe | (driveTx & ~txMsb);
endmodule

// File: rtl/i2cpg_data.sv
module i2cpg_data
  import i2cpg_pkg::*;
#(
  parameter logic [4:0]        ADDR_HI   = 5'b11101,
  parameter logic [BYTE_W-1:0] CMD_ADDR  = 8'hFD,
  parameter logic [BYTE_W-1:0] FUNC_PAGE = 8'h0B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic              strapPin,
  input  logic              shutdown,
  input  strobe_t           strb,
  input  logic [BYTE_W-1:0] regRData,
  output logic              addrMatch,
  output logic              isRead,
  output logic              txMsb,
  output logic              regWe,
  output logic [BYTE_W-1:0] regPage,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWData
);
  logic [BYTE_W-1:0] rxShift, txShift, ptr, page, rdVal;
  logic [1:0] strapPipe, strapBits;
  logic strapS, diffScl, diffSda;

  // strap pin follows the same synchronizer depth as the bus lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapPipe <= 2'b11;
      diffScl   <= 1'b0;
      diffSda   <= 1'b0;
    end else begin
      strapPipe <= {strapPipe[0], strapPin};
      if (strapS != sclS) diffScl <= 1'b1;
      if (strapS != sdaS) diffSda <= 1'b1;
    end
  end

  assign strapS = strapPipe[1];

  always_comb begin
    if (!diffScl)      strapBits = 2'b01;
    else if (!diffSda) strapBits = 2'b10;
    else               strapBits = {2{strapS}};
  end

  assign addrMatch = (rxShift[BYTE_W-1:1] == {ADDR_HI, strapBits});
  assign isRead    = rxShift[0];

  always_comb begin
    if (ptr == CMD_ADDR)                        rdVal = page;
    else if (page == FUNC_PAGE || shutdown)     rdVal = regRData;
    else                                        rdVal = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
      page    <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      if (strb.setPtr)  ptr <= rxShift;
      if (strb.wrByte) begin
        if (ptr == CMD_ADDR) page <= rxShift;
        ptr <= ptr + 1'b1;
      end
      if (strb.incPtr)  ptr <= ptr + 1'b1;
      if (strb.loadTx)       txShift <= rdVal;
      else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign txMsb    = txShift[BYTE_W-1];
  assign regWe    = strb.wrByte && (ptr != CMD_ADDR);
  assign regAddr  = ptr;
  assign regPage  = page;
  assign regWData = rxShift;
endmodule

// File: rtl/i2c_page_slave.sv
module i2c_page_slave
  import i2cpg_pkg::*;
#(
  parameter logic [4:0]        ADDR_HI   = 5'b11101,
  parameter logic [BYTE_W-1:0] CMD_ADDR  = 8'hFD,
  parameter logic [BYTE_W-1:0] FUNC_PAGE = 8'h0B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              strapPin,
  input  logic              shutdown,
  output logic              sdaOe,
  output logic              regWe,
  output logic [BYTE_W-1:0] regPage,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWData,
  input  logic [BYTE_W-1:0] regRData
);
  logic    sclS, sdaS, addrMatch, isRead, txMsb;
  strobe_t strb;

  i2cpg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrMatch(addrMatch), .isRead(isRead), .txMsb(txMsb),
    .sclS(sclS), .sdaS(sdaS), .strb(strb), .sdaOe(sdaOe)
  );

  i2cpg_data #(.ADDR_HI(ADDR_HI), .CMD_ADDR(CMD_ADDR), .FUNC_PAGE(FUNC_PAGE)) data_i (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .strapPin(strapPin),
    .shutdown(shutdown), .strb(strb), .regRData(regRData),
    .addrMatch(addrMatch), .isRead(isRead), .txMsb(txMsb), .regWe(regWe),
    .regPage(regPage), .regAddr(regAddr), .regWData(regWData)
  );
endmodule

// File: rtl/i2cpg_chk.sv
module i2cpg_chk #(
  parameter logic [7:0] CMD_ADDR = 8'hFD
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclS,
  input logic       sdaOe,
  input logic       regWe,
  input logic [7:0] regAddr,
  input logic [7:0] regPage
);
  // R5: a write strobe lasts exactly one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R5: the pointer advances by one after each written byte
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> regAddr == $past(regAddr) + 8'd1);

  // R6: the command address never reaches the register file
  a_r6_cmd_no_write: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> regAddr != CMD_ADDR);

  // R6: the page selector only moves after a byte at the command address
  a_r6_page_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regPage) |-> $past(regAddr) == CMD_ADDR);

  // R10: the data line is only changed while the clock is low
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);
endmodule

bind i2c_page_slave i2cpg_chk #(.CMD_ADDR(CMD_ADDR)) chk_i (
  .clk(clk), .rstN(rstN), .sclS(sclS), .sdaOe(sdaOe),
  .regWe(regWe), .regAddr(regAddr), .regPage(regPage)
);

// File: tb/i2c_page_slave_tb.sv
module i2c_page_slave_tb_top;
  localparam int QP = 5;
  localparam logic [7:0] CMD  = 8'hFD;
  localparam logic [7:0] FUNC = 8'h0B;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic shutdown = 1'b0;
  int   strapMode = 0;
  logic sdaOe, regWe, strapPin, sclBus, sdaBus;
  logic [7:0] regPage, regAddr, regWData, regRData;

  logic [7:0] mem    [0:15][0:255];
  logic [7:0] expMem [0:15][0:255];
  logic [7:0] expPage;
  logic [6:0] devAddr;
  logic [7:0] wBuf [0:7];
  logic [7:0] rBuf [0:7];
  int nChecks = 0, nFail = 0, weCount = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sclBus   = mScl;
  assign sdaBus   = mSda & ~sdaOe;
  assign strapPin = (strapMode == 0) ? 1'b0 : (strapMode == 1) ? 1'b1 :
                    (strapMode == 2) ? sclBus : sdaBus;
  assign regRData = mem[regPage[3:0]][regAddr];

  i2c_page_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus), .strapPin(strapPin),
    .shutdown(shutdown), .sdaOe(sdaOe), .regWe(regWe), .regPage(regPage),
    .regAddr(regAddr), .regWData(regWData), .regRData(regRData)
  );

  always @(posedge clk) begin
    if (regWe) begin
      mem[regPage[3:0]][regAddr] <= regWData;
      weCount <= weCount + 1;
    end
  end

  function automatic logic [1:0] strapCode(int m);
    case (m)
      0: return 2'b00;
      1: return 2'b11;
      2: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; wt(QP);
    mScl = 1'b1; wt(QP);
    mSda = 1'b0; wt(QP);
    mScl = 1'b0; wt(QP);
  endtask

  task automatic busStop();
    mSda = 1'b0; wt(QP);
    mScl = 1'b1; wt(QP);
    mSda = 1'b1; wt(QP);
  endtask

  task automatic sendBit(logic b);
    mSda = b; wt(QP);
    mScl = 1'b1; wt(2 * QP);
    mScl = 1'b0; wt(QP);
  endtask

  task automatic recvBit(output logic b);
    mSda = 1'b1; wt(QP);
    mScl = 1'b1; wt(QP);
    b = sdaBus; wt(QP);
    mScl = 1'b0; wt(QP);
  endtask

  task automatic sendByte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(logic nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recvBit(v[i]);
    sendBit(nack);
  endtask

  task automatic doReset();
    rstN = 1'b0; wt(4);
    rstN = 1'b1; wt(4);
    expPage = 8'h00;
  endtask

  // write n bytes from wBuf starting at ptr, updating the model
  task automatic writeBurst(logic [7:0] ptr, int n);
    logic ack;
    logic [7:0] p;
    busStart();
    sendByte({devAddr, 1'b0}, ack); check("R2", "write address ack", {7'd0, ack}, 8'd1);
    sendByte(ptr, ack);             check("R4", "register byte ack", {7'd0, ack}, 8'd1);
    p = ptr;
    for (int i = 0; i < n; i++) begin
      sendByte(wBuf[i], ack);       check("R5", "data byte ack", {7'd0, ack}, 8'd1);
      if (p == CMD) expPage = wBuf[i];
      else expMem[expPage[3:0]][p] = wBuf[i];
      p = p + 8'd1;
    end
    busStop();
    check("R5", "pointer after burst", regAddr, p);
  endtask

  // read n bytes at ptr through a repeated START and check against the model
  task automatic readBurst(logic [7:0] ptr, int n, string req);
    logic ack;
    logic [7:0] p, e;
    busStart();
    sendByte({devAddr, 1'b0}, ack);
    sendByte(ptr, ack);
    busStart();
    sendByte({devAddr, 1'b1}, ack); check("R7", "read address ack", {7'd0, ack}, 8'd1);
    p = ptr;
    for (int i = 0; i < n; i++) begin
      recvByte(i == n - 1, rBuf[i]);
      if (p == CMD) e = expPage;
      else if (expPage == FUNC || shutdown) e = expMem[expPage[3:0]][p];
      else e = 8'h00;
      check(req, "read data", rBuf[i], e);
      if (i != n - 1) p = p + 8'd1;
    end
    check("R7", "sda released after nack", {7'd0, sdaOe}, 8'd0);
    busStop();
    check("R7", "pointer after read", regAddr, p);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  initial begin
    logic ack;
    logic [6:0] cand;
    logic [1:0] code;
    int we0;
    for (int p = 0; p < 16; p++)
      for (int a = 0; a < 256; a++) begin
        mem[p][a]    = 8'((p * 37 + a * 5 + 3) & 255);
        expMem[p][a] = 8'((p * 37 + a * 5 + 3) & 255);
      end

    // R1: reset state
    doReset();
    check("R1", "sdaOe after reset", {7'd0, sdaOe}, 8'd0);
    check("R1", "regPage after reset", regPage, 8'h00);
    check("R1", "regAddr after reset", regAddr, 8'h00);
    check("R1", "regWe after reset", {7'd0, regWe}, 8'd0);

    // R2/R3: address sweep for each strap connection
    for (int m = 0; m < 4; m++) begin
      strapMode = (m + 1) % 4;
      code = strapCode(strapMode);
      doReset();
      for (int k = 0; k < 9; k++) begin
        if (k < 4) cand = {5'b11101, 2'(k)};
        else       cand = {5'b11101 ^ (5'b00001 << (k - 4)), code};
        we0 = weCount;
        busStart();
        sendByte({cand, 1'b0}, ack);
        check("R3", "address ack vs strap", {7'd0, ack}, {7'd0, cand == {5'b11101, code}});
        if (!ack) begin
          sendByte(8'h10, ack);
          check("R2", "no ack after mismatch", {7'd0, ack}, 8'd0);
          sendByte(8'hA5, ack);
          check("R2", "no write after mismatch", 8'(weCount - we0), 8'd0);
        end
        busStop();
      end
    end
    devAddr = {5'b11101, strapCode(strapMode)};  // strap to ground

    // R6: page select, R4/R5: burst
    wBuf[0] = 8'h03;
    writeBurst(CMD, 1);
    check("R6", "page after select", regPage, 8'h03);
    for (int i = 0; i < 6; i++) wBuf[i] = 8'(8'h40 + i * 3);
    writeBurst(8'h20, 6);
    for (int a = 8'h1F; a <= 8'h26; a++)
      check("R5", "burst location", mem[3][a], expMem[3][a]);

    // R6: burst across the command register, R5: pointer wrap
    wBuf[0] = 8'hB0; wBuf[1] = 8'hB1; wBuf[2] = 8'h05;
    wBuf[3] = 8'hC0; wBuf[4] = 8'hC1; wBuf[5] = 8'hC2;
    we0 = weCount;
    writeBurst(8'hFB, 6);
    check("R6", "writes across command", 8'(weCount - we0), 8'd5);
    check("R6", "page switched mid-burst", regPage, 8'h05);
    check("R6", "page3 FB", mem[3][8'hFB], 8'hB0);
    check("R6", "page3 FC", mem[3][8'hFC], 8'hB1);
    check("R6", "page5 FE", mem[5][8'hFE], 8'hC0);
    check("R6", "page5 FF", mem[5][8'hFF], 8'hC1);
    check("R5", "wrap to page5 00", mem[5][8'h00], 8'hC2);
    check("R6", "page3 FE untouched", mem[3][8'hFE], expMem[3][8'hFE]);

    // R8: frame page outside shutdown reads zero, memory kept
    shutdown = 1'b0;
    readBurst(8'hFE, 3, "R8");
    check("R8", "frame data kept", mem[5][8'hFE], 8'hC0);
    // R8: in shutdown the same page reads back
    shutdown = 1'b1;
    readBurst(8'hFE, 3, "R8");
    readBurst(CMD, 1, "R6");

    // R7/R8: function page readable outside shutdown
    shutdown = 1'b0;
    wBuf[0] = FUNC;
    writeBurst(CMD, 1);
    for (int i = 0; i < 4; i++) wBuf[i] = 8'(8'h91 ^ (i * 8'h22));
    writeBurst(8'h00, 4);
    readBurst(8'h00, 4, "R7");
    readBurst(8'h02, 1, "R8");

    // R9: bytes after STOP without START are ignored
    we0 = weCount;
    sendByte({devAddr, 1'b0}, ack);
    check("R9", "no ack without start", {7'd0, ack}, 8'd0);
    sendByte(8'h33, ack);
    check("R9", "no ack for data without start", {7'd0, ack}, 8'd0);
    check("R9", "no write without start", 8'(weCount - we0), 8'd0);
    busStop();

    // R9: repeated START inside a write burst
    busStart();
    sendByte({devAddr, 1'b0}, ack);
    sendByte(8'h40, ack);
    sendByte(8'h11, ack);
    busStart();
    sendByte({devAddr, 1'b0}, ack);
    check("R9", "ack after repeated start", {7'd0, ack}, 8'd1);
    sendByte(8'h50, ack);
    sendByte(8'h22, ack);
    busStop();
    check("R9", "first segment byte", mem[FUNC[3:0]][8'h40], 8'h11);
    check("R9", "second segment byte", mem[FUNC[3:0]][8'h50], 8'h22);
    check("R9", "released after stop", {7'd0, sdaOe}, 8'd0);

    wt(10);
    done = 1;
    finishRun();
  end
endmodule